// File: doc/BRIEF.md
# Polled Accelerator Launch Frame

This block is a CPU-facing register frame for handing work to up to eight attached accelerators without any interrupt. Software stages a 512-bit operand block in eight 64-bit data words. It then writes a launch word that holds an opcode and an accelerator index. The frame sends the staged words and the launch word out together as a single launch beat. Software then polls a launch-response register until the accelerator has acknowledged the launch.

Work that goes on after the launch is reported through a status register. That register holds a ready flag, which follows the accelerator's ability to take more commands, and a sticky fault flag. The fault flag clears only when software issues a resolve launch. A one-cycle wake pulse marks every change of the status register, so a CPU waiting for an event can resume. Only aligned 64-bit accesses have any effect. Every other access reads zero and its write is dropped.

Top module: `accel_launch_frame`

## Requirements
- R1: Word offsets 0x00, 0x08 … 0x38 (word index = busAddr[6:3], values 0 to 7) are data words. They keep whatever 64-bit value is written to them and return it on a read.
- R2: An access has an effect only when busSize is 3 (8 bytes) and busAddr[2:0] is 0. Any other read returns 0, and any other write changes no register and starts no launch.
- R3: A write to offset 0x40 launches. Opcode is wdata[7:0] and accelerator index is wdata[10:8]. Opcode 1 (execute) and opcode 2 (resolve) are valid. A valid launch written while no launch is pending drives launchValid for exactly one cycle, starting at the edge that takes the write. launchOpcode and launchAccel carry the written fields. launchPayload carries data word k at bits [64k+63:64k]. The response then reads 1 (pending).
- R4: The launch response reads at offset 0x48 and is 0 (idle) after reset. A launchAck that arrives while a launch is pending sets it to 2 (accepted) and ends the pending state. An ack that arrives with nothing pending has no effect.
- R5: A launch write that arrives while a launch is pending produces no launchValid and sets the response to 3 (busy). The earlier launch stays pending. If an ack arrives at the same edge, the response becomes 2.
- R6: A launch write with any opcode other than 1 or 2, made while nothing is pending, produces no launchValid and sets the response to 4 (bad opcode).
- R7: The status register reads at offset 0x50. Bit 0 is accelReady as sampled at the previous edge. Bit 1 (fault) is set by faultReport and cleared by an issued resolve launch. If both happen at the same edge, the set wins.
- R8: wakeEvent is high for exactly those cycles in which the status register differs from its value in the previous cycle.
- R9: Writes to 0x48, 0x50 and to unmapped offsets have no effect. Reads of 0x40 and of unmapped offsets return 0.
- R10: After reset, launchValid and wakeEvent are low, and every readable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busReq | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Byte offset into the frame |
| busSize | input | 2 | log2 of the access size in bytes |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Read data, same cycle as busReq |
| launchValid | output | 1 | One-cycle launch beat |
| launchAccel | output | 3 | Target accelerator index |
| launchOpcode | output | 8 | Launch opcode |
| launchPayload | output | 512 | Snapshot of the eight data words |
| launchAck | input | 1 | Accelerator took the pending launch |
| accelReady | input | 1 | Accelerator can take further commands |
| faultReport | input | 1 | Translation fault pulse |
| wakeEvent | output | 1 | Status-change pulse |

## Verification
The hardest states to reach are collisions at a single edge. These include a launch write landing on a pending launch in the same cycle as its ack, and a fault report arriving together with a resolve launch. Directed sequences set up each of these on purpose. A long random phase then mixes malformed sizes, misaligned offsets, invalid opcodes, stray acks and fault pulses, while a behavioural model checks the launch beat, the wake pulse and every readback.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int WORD_W = 64;
  localparam int OPC_W  = 8;

  localparam logic [OPC_W-1:0] OP_EXEC    = 8'h01;
  localparam logic [OPC_W-1:0] OP_RESOLVE = 8'h02;

  typedef enum logic [2:0] {
    LR_IDLE     = 3'd0,
    LR_PENDING  = 3'd1,
    LR_ACCEPTED = 3'd2,
    LR_BUSY     = 3'd3,
    LR_BADOP    = 3'd4
  } lrespCode_t;

  // datapath -> control
  typedef struct packed {
    logic             launchWr;
    logic [OPC_W-1:0] opcode;
  } dpToCtrl_t;

  // control -> datapath
  typedef struct packed {
    logic       issue;
    lrespCode_t lresp;
    logic [1:0] status;
  } ctrlToDp_t;
endpackage

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 7,
  parameter int ACC_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        busReq,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [1:0]                  busSize,
  input  logic [WORD_W-1:0]           busWdata,
  output logic [WORD_W-1:0]           busRdata,
  input  ctrlToDp_t                   fromCtrl,
  output dpToCtrl_t                   toCtrl,
  output logic                        launchValid,
  output logic [ACC_W-1:0]            launchAccel,
  output logic [OPC_W-1:0]            launchOpcode,
  output logic [NUM_WORDS*WORD_W-1:0] launchPayload
);
  localparam int WIDX_W = ADDR_W - 3;
  localparam int DIDX_W = $clog2(NUM_WORDS);
  localparam logic [WIDX_W-1:0] LAUNCH_IDX = WIDX_W'(NUM_WORDS);
  localparam logic [WIDX_W-1:0] LRESP_IDX  = WIDX_W'(NUM_WORDS + 1);
  localparam logic [WIDX_W-1:0] STATUS_IDX = WIDX_W'(NUM_WORDS + 2);

  logic              accessOk;
  logic [WIDX_W-1:0] wordIdx;
  logic [WORD_W-1:0] dataReg [NUM_WORDS];
  logic [NUM_WORDS*WORD_W-1:0] dataFlat;

  assign accessOk = busReq && (busSize == 2'd3) && (busAddr[2:0] == 3'd0);
  assign wordIdx  = busAddr[ADDR_W-1:3];

  assign toCtrl.launchWr = accessOk && busWrite && (wordIdx == LAUNCH_IDX);
  assign toCtrl.opcode   = busWdata[OPC_W-1:0];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        dataReg[i] <= '0;
      else if (accessOk && busWrite && wordIdx == WIDX_W'(i))
        dataReg[i] <= busWdata;
    end
    assign dataFlat[i*WORD_W +: WORD_W] = dataReg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      launchValid   <= 1'b0;
      launchAccel   <= '0;
      launchOpcode  <= '0;
      launchPayload <= '0;
    end else begin
      launchValid <= fromCtrl.issue;
      if (fromCtrl.issue) begin
        launchAccel   <= busWdata[OPC_W +: ACC_W];
        launchOpcode  <= busWdata[OPC_W-1:0];
        launchPayload <= dataFlat;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (accessOk && !busWrite) begin
      if (wordIdx < WIDX_W'(NUM_WORDS))
        busRdata = dataReg[wordIdx[DIDX_W-1:0]];
      else if (wordIdx == LRESP_IDX)
        busRdata = WORD_W'(fromCtrl.lresp);
      else if (wordIdx == STATUS_IDX)
        busRdata = WORD_W'(fromCtrl.status);
    end
  end
endmodule

// File: rtl/frame_control.sv
module frame_control
  import frame_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dpToCtrl_t fromDp,
  input  logic      launchAck,
  input  logic      accelReady,
  input  logic      faultReport,
  output ctrlToDp_t toDp,
  output logic      wakeEvent
);
  lrespCode_t lrespReg;
  logic       pending;
  logic       opValid;
  logic       issue;
  logic [1:0] statusReg;
  logic [1:0] statusNext;
  logic       faultNext;

  assign opValid = (fromDp.opcode == OP_EXEC) || (fromDp.opcode == OP_RESOLVE);
  assign issue   = fromDp.launchWr && !pending && opValid;

  assign faultNext  = faultReport ||
                      (statusReg[1] && !(issue && fromDp.opcode == OP_RESOLVE));
  assign statusNext = {faultNext, accelReady};

  always_ff @(posedge clk) begin
    if (rst) begin
      lrespReg  <= LR_IDLE;
      pending   <= 1'b0;
      statusReg <= '0;
      wakeEvent <= 1'b0;
    end else begin
      if (fromDp.launchWr) begin
        if (pending)
          lrespReg <= LR_BUSY;
        else if (opValid) begin
          lrespReg <= LR_PENDING;
          pending  <= 1'b1;
        end else
          lrespReg <= LR_BADOP;
      end
      if (launchAck && pending) begin
        lrespReg <= LR_ACCEPTED;
        pending  <= 1'b0;
      end
      statusReg <= statusNext;
      wakeEvent <= (statusNext != statusReg);
    end
  end

  assign toDp.issue  = issue;
  assign toDp.lresp  = lrespReg;
  assign toDp.status = statusReg;
endmodule

// File: rtl/accel_launch_frame.sv
module accel_launch_frame
  import frame_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 7,
  parameter int ACC_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        busReq,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [1:0]                  busSize,
  input  logic [WORD_W-1:0]           busWdata,
  output logic [WORD_W-1:0]           busRdata,
  output logic                        launchValid,
  output logic [ACC_W-1:0]            launchAccel,
  output logic [OPC_W-1:0]            launchOpcode,
  output logic [NUM_WORDS*WORD_W-1:0] launchPayload,
  input  logic                        launchAck,
  input  logic                        accelReady,
  input  logic                        faultReport,
  output logic                        wakeEvent
);
  dpToCtrl_t dpToCtrl;
  ctrlToDp_t ctrlToDp;

  frame_datapath #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .ACC_W(ACC_W)
  ) i_dp (
    .clk(clk), .rst(rst),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .fromCtrl(ctrlToDp), .toCtrl(dpToCtrl),
    .launchValid(launchValid), .launchAccel(launchAccel),
    .launchOpcode(launchOpcode), .launchPayload(launchPayload)
  );

  frame_control i_ctrl (
    .clk(clk), .rst(rst),
    .fromDp(dpToCtrl), .launchAck(launchAck),
    .accelReady(accelReady), .faultReport(faultReport),
    .toDp(ctrlToDp), .wakeEvent(wakeEvent)
  );
endmodule

// File: rtl/frame_checker.sv
module frame_checker (
  input logic       clk,
  input logic       rst,
  input logic       busReq,
  input logic       busWrite,
  input logic [1:0] busSize,
  input logic       launchValid,
  input logic       launchAck,
  input logic       accelReady,
  input logic       faultReport,
  input logic       wakeEvent,
  input logic [2:0] lresp,
  input logic [1:0] status
);
  // R3
  single_beat_chk: assert property (@(posedge clk) disable iff (rst)
    launchValid |=> !launchValid);

  // R3
  beat_pending_chk: assert property (@(posedge clk) disable iff (rst)
    launchValid |-> (lresp == 3'd1));

  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (busReq && busWrite && busSize != 2'd3) |=> !launchValid);

  // R4
  ack_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (launchValid && launchAck) |=> (lresp == 3'd2));

  // R7
  fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    faultReport |=> status[1]);

  // R7
  ready_hi_chk: assert property (@(posedge clk) disable iff (rst)
    accelReady |=> status[0]);

  // R7
  ready_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !accelReady |=> !status[0]);

  // R8
  wake_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (status != $past(status)) |-> wakeEvent);

  // R8
  wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(status) |-> !wakeEvent);
endmodule

bind accel_launch_frame frame_checker i_chk (
  .clk(clk), .rst(rst),
  .busReq(busReq), .busWrite(busWrite), .busSize(busSize),
  .launchValid(launchValid), .launchAck(launchAck),
  .accelReady(accelReady), .faultReport(faultReport),
  .wakeEvent(wakeEvent),
  .lresp(ctrlToDp.lresp), .status(ctrlToDp.status)
);

// File: tb/test_accel_launch_frame.sv
`timescale 1ns/1ps
module test_accel_launch_frame;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         busReq = 1'b0, busWrite = 1'b0;
  logic [6:0]   busAddr = '0;
  logic [1:0]   busSize = '0;
  logic [63:0]  busWdata = '0;
  logic [63:0]  busRdata;
  logic         launchValid;
  logic [2:0]   launchAccel;
  logic [7:0]   launchOpcode;
  logic [511:0] launchPayload;
  logic         launchAck = 1'b0, accelReady = 1'b0, faultReport = 1'b0;
  logic         wakeEvent;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  accel_launch_frame i_accel_launch_frame (
    .clk(clk), .rst(rst), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .launchValid(launchValid),
    .launchAccel(launchAccel), .launchOpcode(launchOpcode),
    .launchPayload(launchPayload), .launchAck(launchAck),
    .accelReady(accelReady), .faultReport(faultReport),
    .wakeEvent(wakeEvent)
  );

  // behavioural reference
  logic [63:0] mData [8];
  int          mLresp;
  bit          mPend, mFault, mReady;
  bit          eValid, eWake;
  logic [7:0]  eOpc;
  logic [2:0]  eAcc;
  logic [63:0] ePay [8];

  always @(posedge clk) begin
    if (rst) begin
      foreach (mData[i]) begin mData[i] = '0; ePay[i] = '0; end
      mLresp = 0; mPend = 0; mFault = 0; mReady = 0;
      eValid = 0; eWake = 0; eOpc = '0; eAcc = '0;
    end else begin
      bit ok, nFault, nPend;
      int nLresp;
      ok = busReq && busSize == 2'd3 && busAddr[2:0] == 3'd0;
      nFault = mFault; nPend = mPend; nLresp = mLresp;
      eValid = 0;
      if (ok && busWrite && busAddr < 7'h40) mData[busAddr[5:3]] = busWdata;
      if (ok && busWrite && busAddr == 7'h40) begin
        if (mPend) nLresp = 3;
        else if (busWdata[7:0] == 8'd1 || busWdata[7:0] == 8'd2) begin
          eValid = 1; nLresp = 1; nPend = 1;
          eOpc = busWdata[7:0]; eAcc = busWdata[10:8];
          foreach (ePay[i]) ePay[i] = mData[i];
          if (busWdata[7:0] == 8'd2) nFault = 0;
        end else nLresp = 4;
      end
      if (launchAck && mPend) begin nLresp = 2; nPend = 0; end
      if (faultReport) nFault = 1;
      eWake  = (nFault != mFault) || (accelReady != mReady);
      mFault = nFault; mReady = accelReady; mPend = nPend; mLresp = nLresp;
    end
  end

  function automatic logic [63:0] modelRead(logic [6:0] a, logic [1:0] s);
    if (s != 2'd3 || a[2:0] != 3'd0) return '0;
    if (a < 7'h40) return mData[a[5:3]];
    if (a == 7'h48) return 64'(mLresp);
    if (a == 7'h50) return {62'd0, mFault, mReady};
    return '0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 launchValid", 64'(launchValid), 64'(eValid));
      chk("R8 wakeEvent", 64'(wakeEvent), 64'(eWake));
      if (eValid) begin
        chk("R3 launchOpcode", 64'(launchOpcode), 64'(eOpc));
        chk("R3 launchAccel", 64'(launchAccel), 64'(eAcc));
        for (int k = 0; k < 8; k++)
          chk("R3 launchPayload", launchPayload[k*64 +: 64], ePay[k]);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    busReq = 0; busWrite = 0; launchAck = 0; faultReport = 0;
  endtask

  task automatic wr(logic [6:0] a, logic [1:0] s, logic [63:0] d);
    @(negedge clk);
    busReq = 1; busWrite = 1; busAddr = a; busSize = s; busWdata = d;
    launchAck = 0; faultReport = 0;
  endtask

  task automatic rd(logic [6:0] a, logic [1:0] s, logic [63:0] exp, string tag);
    @(negedge clk);
    busReq = 1; busWrite = 0; busAddr = a; busSize = s;
    launchAck = 0; faultReport = 0;
    #1;
    chk(tag, busRdata, exp);
    chk({tag, " model"}, busRdata, modelRead(a, s));
  endtask

  task automatic ack();
    @(negedge clk);
    busReq = 0; busWrite = 0; launchAck = 1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 launchValid", 64'(launchValid), 0);
    chk("R10 wakeEvent", 64'(wakeEvent), 0);
    rd(7'h48, 3, 0, "R10 lresp");
    rd(7'h50, 3, 0, "R10 status");
    rd(7'h18, 3, 0, "R10 data3");

    // R1 data words
    for (int k = 0; k < 8; k++) wr(7'(k*8), 3, 64'hA5A5_0000_0000_0000 | 64'(k*17+3));
    for (int k = 0; k < 8; k++) rd(7'(k*8), 3, 64'hA5A5_0000_0000_0000 | 64'(k*17+3), "R1 data");

    // R2 size and alignment
    wr(7'h08, 2, 64'hDEAD);
    wr(7'h0C, 3, 64'hBEEF);
    rd(7'h08, 3, 64'hA5A5_0000_0000_0014, "R2 data1 kept");
    rd(7'h08, 2, 0, "R2 narrow read");
    rd(7'h09, 3, 0, "R2 misaligned read");
    wr(7'h40, 1, 64'h0501);
    idle();
    rd(7'h48, 3, 0, "R2 narrow launch");

    // R3 launch
    wr(7'h40, 3, 64'h0501);
    idle();
    rd(7'h48, 3, 1, "R3 lresp pending");
    rd(7'h40, 3, 0, "R9 launch read zero");
    // R5 busy
    wr(7'h40, 3, 64'h0201);
    idle();
    rd(7'h48, 3, 3, "R5 lresp busy");
    // R4 accept
    ack(); idle();
    rd(7'h48, 3, 2, "R4 lresp accepted");
    ack(); idle();
    rd(7'h48, 3, 2, "R4 stray ack");
    // R6 bad opcode
    wr(7'h40, 3, 64'h0307);
    idle();
    rd(7'h48, 3, 4, "R6 lresp badop");
    wr(7'h40, 3, 64'h0300);
    idle();
    rd(7'h48, 3, 4, "R6 opcode zero");

    // R5 collision: launch while pending, ack same edge
    wr(7'h10, 3, 64'h1234);
    wr(7'h40, 3, 64'h0701);
    idle();
    @(negedge clk);
    busReq = 1; busWrite = 1; busAddr = 7'h40; busSize = 3; busWdata = 64'h0101;
    launchAck = 1;
    idle();
    rd(7'h48, 3, 2, "R5 ack wins");

    // R7 fault and resolve
    @(negedge clk); faultReport = 1;
    idle();
    rd(7'h50, 3, 2, "R7 fault set");
    wr(7'h40, 3, 64'h0002);
    idle();
    rd(7'h50, 3, 0, "R7 fault cleared");
    ack(); idle();
    // resolve with fault at same edge: set wins
    @(negedge clk); faultReport = 1; idle();
    @(negedge clk);
    busReq = 1; busWrite = 1; busAddr = 7'h40; busSize = 3; busWdata = 64'h0002;
    faultReport = 1;
    idle();
    rd(7'h50, 3, 2, "R7 set wins");
    ack(); idle();
    @(negedge clk); accelReady = 1;
    idle();
    rd(7'h50, 3, 3, "R7 ready");
    @(negedge clk); accelReady = 0;
    idle();

    // R9 read-only and unmapped
    wr(7'h48, 3, 64'h7);
    wr(7'h50, 3, 64'h3);
    wr(7'h60, 3, 64'hFFFF);
    idle();
    rd(7'h48, 3, 2, "R9 lresp write ignored");
    rd(7'h50, 3, 2, "R9 status write ignored");
    rd(7'h60, 3, 0, "R9 unmapped read");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      busReq      = ($urandom_range(0, 3) != 0);
      busWrite    = $urandom_range(0, 1);
      busAddr     = 7'($urandom_range(0, 12) * 8) | (($urandom_range(0, 7) == 0) ? 7'd4 : 7'd0);
      busSize     = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 2)) : 2'd3;
      busWdata    = {$urandom, 21'd0, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 3))};
      launchAck   = ($urandom_range(0, 3) == 0);
      faultReport = ($urandom_range(0, 15) == 0);
      accelReady  = ($urandom_range(0, 5) != 0) ? accelReady : ~accelReady;
      if (busReq && !busWrite) begin
        #1;
        chk("R1 R2 R9 random read", busRdata, modelRead(busAddr, busSize));
      end
    end
    idle();
    rd(7'h48, 3, modelRead(7'h48, 3), "R4 final lresp");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule